// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge Interrupts

This block is one bank of 32 general-purpose pins on a simple 32-bit register bus. Software sets or clears output levels and pin directions one bit at a time through separate set and clear addresses, so no read-modify-write is needed. It can remove a pin's pull or hand the pin over to a peripheral. Reads of the data word return the synchronised level on the pads. When a pin is an input with its pull enabled, the stored output bit chooses the pull direction.

Each pin feeds a two-flop synchroniser and then an edge detector. A rising-edge mask and a falling-edge mask are set independently. An enabled edge latches a pending bit in the status word. Software acknowledges a pending bit by writing a one to it. All pending bits are ORed into one interrupt line. Several banks can sit side by side at a 4 KiB stride. Each bank decodes only the low twelve address bits.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads zero except the pull-disable word (offset 0x0C), which reads 0xFFFFFFFF, and `irq` is low.
- R2: A write to offset 0x04 ORs the ones of the written word into the output bits, and a write to 0x08 clears them. Zero bits leave their pins unchanged. A write to 0x00 loads the output bits. `pad_out` shows the output bits one cycle after the write.
- R3: A write to offset 0x14 turns the selected pins into outputs and a write to 0x18 turns them into inputs. A direction bit of 1 drives `pad_oe` high, unless the pin is handed to its peripheral. The direction word reads back at 0x10.
- R4: A read of offset 0x00 returns the pad level. A change on `pad_in` becomes visible after the second rising clock edge.
- R5: For an input pin that is not handed to its peripheral and whose pull-disable bit is 0, an output bit of 1 raises `pad_pull_up` and an output bit of 0 raises `pad_pull_dn`. With the pull-disable bit at 1 both are low, and the two are never high together.
- R6: An alternate-select bit of 1 (offset 0x20) raises `alt_sel` for that pin and forces its `pad_oe` and both pull outputs low.
- R7: A rising edge on a pin whose bit in the rising mask (offset 0x40) is 1 sets that pin's status bit (offset 0x48) at the third rising clock edge after the pad changes.
- R8: A falling edge sets the status bit only when the pin's bit in the falling mask (offset 0x44) is 1. With both masks set, either edge sets it. An edge of a masked-off kind leaves status unchanged.
- R9: Writing ones to offset 0x4C clears those status bits and leaves the others alone. If a new enabled edge on a bit and a clear of that bit land in the same cycle, the bit stays set.
- R10: `irq` is high exactly when some status bit is set.
- R11: Reads of the set, clear and acknowledge aliases (0x04, 0x08, 0x14, 0x18, 0x4C) and of unmapped offsets return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 12 | Byte address inside the bank (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr` (combinational) |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin |
| pad_pull_up | output | 32 | Pull-up enable per pin |
| pad_pull_dn | output | 32 | Pull-down enable per pin |
| alt_sel | output | 32 | Pin handed to its peripheral function |
| irq | output | 1 | OR of all pending status bits |

## Verification
The bench drives an acknowledge of a status bit in the same cycle that a new enabled edge on that bit is detected. A design that applies the clear after the set would drop that interrupt. It raises edges of a masked-off kind, to catch detectors that ignore which mask goes with which edge. It also sets both masks to catch designs that report only one edge. The pull tests cover output, input and alt-selected pins with the pull-disable bit both set and cleared. A wrong gating term there shows up as a pull on a driven pin, or as both pulls at once. The bench counts edges after each pad change, so a synchroniser one stage short or long fails the level read and the status timing.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_pull_up,
  output logic [31:0]       pad_pull_dn,
  output logic [31:0]       alt_sel,
  output logic              irq
);
  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] A_LVL  = WA'(12'h000 >> 2);
  localparam logic [WA-1:0] A_OSET = WA'(12'h004 >> 2);
  localparam logic [WA-1:0] A_OCLR = WA'(12'h008 >> 2);
  localparam logic [WA-1:0] A_NOPL = WA'(12'h00C >> 2);
  localparam logic [WA-1:0] A_DIR  = WA'(12'h010 >> 2);
  localparam logic [WA-1:0] A_DSET = WA'(12'h014 >> 2);
  localparam logic [WA-1:0] A_DCLR = WA'(12'h018 >> 2);
  localparam logic [WA-1:0] A_ALT  = WA'(12'h020 >> 2);
  localparam logic [WA-1:0] A_RMSK = WA'(12'h040 >> 2);
  localparam logic [WA-1:0] A_FMSK = WA'(12'h044 >> 2);
  localparam logic [WA-1:0] A_STAT = WA'(12'h048 >> 2);
  localparam logic [WA-1:0] A_ACK  = WA'(12'h04C >> 2);

  logic [WA-1:0] wsel;
  logic [31:0] outq, dirq, nopull, altq, rmsk, fmsk, stat;
  logic [31:0] sy1, sy2, sy3;
  logic [31:0] hit, ack, pen;

  assign wsel = addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= pad_in;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  assign hit = (sy2 & ~sy3 & rmsk) | (~sy2 & sy3 & fmsk);
  assign ack = (wr_en && wsel == A_ACK) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~ack) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outq   <= '0;
      dirq   <= '0;
      nopull <= '1;
      altq   <= '0;
      rmsk   <= '0;
      fmsk   <= '0;
    end else if (wr_en) begin
      case (wsel)
        A_LVL:   outq   <= wdata;
        A_OSET:  outq   <= outq | wdata;
        A_OCLR:  outq   <= outq & ~wdata;
        A_NOPL:  nopull <= wdata;
        A_DIR:   dirq   <= wdata;
        A_DSET:  dirq   <= dirq | wdata;
        A_DCLR:  dirq   <= dirq & ~wdata;
        A_ALT:   altq   <= wdata;
        A_RMSK:  rmsk   <= wdata;
        A_FMSK:  fmsk   <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (wsel)
      A_LVL:   rdata = sy2;
      A_NOPL:  rdata = nopull;
      A_DIR:   rdata = dirq;
      A_ALT:   rdata = altq;
      A_RMSK:  rdata = rmsk;
      A_FMSK:  rdata = fmsk;
      A_STAT:  rdata = stat;
      default: rdata = '0;
    endcase
  end

  assign pen         = ~dirq & ~nopull & ~altq;
  assign pad_out     = outq;
  assign pad_oe      = dirq & ~altq;
  assign pad_pull_up = pen & outq;
  assign pad_pull_dn = pen & ~outq;
  assign alt_sel     = altq;
  assign irq         = |stat;
endmodule

module gpio_bank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [31:0]       pad_out,
  input logic [31:0]       pad_oe,
  input logic [31:0]       pad_pull_up,
  input logic [31:0]       pad_pull_dn,
  input logic [31:0]       alt_sel,
  input logic              irq
);
  // R5
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_up & pad_pull_dn) == '0);
  // R6
  alt_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_pull_up | pad_pull_dn) & alt_sel) == '0);
  // R2
  oset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h004)) |=> ((pad_out & $past(wdata)) == $past(wdata)));
  // R2
  oclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h008)) |=> ((pad_out & $past(wdata)) == '0));
  // R3
  dset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(12'h014)) |=> (((pad_oe | alt_sel) & $past(wdata)) == $past(wdata)));
  // R10
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(12'h048) && !irq) |-> rdata == '0);
  // R10
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(12'h048) && irq) |-> rdata != '0);
endmodule

bind gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up),
  .pad_pull_dn(pad_pull_dn), .alt_sel(alt_sel), .irq(irq)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rdata, pad_out, pad_oe, pad_pull_up, pad_pull_dn, alt_sel;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn), .alt_sel(alt_sel),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_out, m_dir, m_nopl, m_alt, m_rm, m_fm, m_st;
  logic [31:0] hist[$];

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a & 12'hFFC)
      12'h000: return hist[1];
      12'h00C: return m_nopl;
      12'h010: return m_dir;
      12'h020: return m_alt;
      12'h040: return m_rm;
      12'h044: return m_fm;
      12'h048: return m_st;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_nopl = '1; m_alt = 0; m_rm = 0; m_fm = 0; m_st = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] lvl, prv, cl;
      lvl = hist[1];
      prv = hist[2];
      cl = (wr_en && (addr & 12'hFFC) == 12'h04C) ? wdata : 32'h0;
      m_st = (m_st & ~cl) | (lvl & ~prv & m_rm) | (~lvl & prv & m_fm);
      if (wr_en) begin
        case (addr & 12'hFFC)
          12'h000: m_out = wdata;
          12'h004: m_out = m_out | wdata;
          12'h008: m_out = m_out & ~wdata;
          12'h00C: m_nopl = wdata;
          12'h010: m_dir = wdata;
          12'h014: m_dir = m_dir | wdata;
          12'h018: m_dir = m_dir & ~wdata;
          12'h020: m_alt = wdata;
          12'h040: m_rm = wdata;
          12'h044: m_fm = wdata;
          default: ;
        endcase
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] pe;
      pe = ~m_dir & ~m_nopl & ~m_alt;
      check("R11 model rdata", rdata, m_read(addr));
      check("R2 model pad_out", pad_out, m_out);
      check("R3 model pad_oe", pad_oe, m_dir & ~m_alt);
      check("R5 model pull_up", pad_pull_up, pe & m_out);
      check("R5 model pull_dn", pad_pull_dn, pe & ~m_out);
      check("R6 model alt_sel", alt_sel, m_alt);
      check("R10 model irq", {31'h0, irq}, {31'h0, |m_st});
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step(1);
    wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic port(input string tag, input logic [31:0] act, input logic [31:0] exp);
    #1;
    check(tag, act, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    // R1 reset state
    rd("R1 data", 12'h000, 32'h0);
    rd("R1 nopull", 12'h00C, 32'hFFFF_FFFF);
    rd("R1 dir", 12'h010, 32'h0);
    rd("R1 alt", 12'h020, 32'h0);
    rd("R1 rmask", 12'h040, 32'h0);
    rd("R1 fmask", 12'h044, 32'h0);
    rd("R1 status", 12'h048, 32'h0);
    port("R1 irq", {31'h0, irq}, 32'h0);
    // R2 data aliases
    wr(12'h000, 32'h0000_00F0);
    wr(12'h004, 32'h0000_000F);
    port("R2 set", pad_out, 32'h0000_00FF);
    wr(12'h008, 32'h0000_0030);
    port("R2 clear", pad_out, 32'h0000_00CF);
    // R3 direction aliases
    wr(12'h014, 32'h0000_FFFF);
    port("R3 dir set", pad_oe, 32'h0000_FFFF);
    wr(12'h018, 32'h0000_00FF);
    port("R3 dir clear", pad_oe, 32'h0000_FF00);
    rd("R3 dir read", 12'h010, 32'h0000_FF00);
    // R11 alias reads zero, unmapped write ignored
    rd("R11 oset reads zero", 12'h004, 32'h0);
    rd("R11 dset reads zero", 12'h014, 32'h0);
    wr(12'h030, 32'hFFFF_FFFF);
    rd("R11 unmapped read", 12'h030, 32'h0);
    port("R11 unmapped no effect", pad_oe, 32'h0000_FF00);
    // R4 synchronised level
    pad_in = 32'hA5A5_0001;
    addr = 12'h000;
    step(1);
    rd("R4 level one edge", 12'h000, 32'h0);
    step(1);
    rd("R4 level two edges", 12'h000, 32'hA5A5_0001);
    // R5 pulls
    wr(12'h00C, 32'h0);
    port("R5 pull up", pad_pull_up, 32'h0000_00CF);
    port("R5 pull down", pad_pull_dn, 32'hFFFF_0030);
    wr(12'h00C, 32'hFFFF_0000);
    port("R5 pull up partial", pad_pull_up, 32'h0000_00CF);
    port("R5 pull down partial", pad_pull_dn, 32'h0000_0030);
    // R6 alternate function
    wr(12'h020, 32'h0000_0F0F);
    port("R6 oe", pad_oe, 32'h0000_F000);
    port("R6 pull up", pad_pull_up, 32'h0000_00C0);
    port("R6 pull down", pad_pull_dn, 32'h0000_0030);
    port("R6 alt_sel", alt_sel, 32'h0000_0F0F);
    // interrupts
    pad_in = 32'h0;
    step(4);
    rd("R8 no mask no status", 12'h048, 32'h0);
    wr(12'h040, 32'h0000_0005);
    wr(12'h044, 32'h0000_0006);
    pad_in = 32'h1;
    step(2);
    port("R7 irq not yet", {31'h0, irq}, 32'h0);
    step(1);
    port("R10 irq raised", {31'h0, irq}, 32'h1);
    rd("R7 rising sets", 12'h048, 32'h1);
    pad_in = 32'h0;
    step(4);
    rd("R8 unmasked fall ignored", 12'h048, 32'h1);
    wr(12'h04C, 32'h1);
    rd("R9 ack clears", 12'h048, 32'h0);
    port("R10 irq drops", {31'h0, irq}, 32'h0);
    pad_in = 32'h2;
    step(4);
    rd("R8 unmasked rise ignored", 12'h048, 32'h0);
    pad_in = 32'h0;
    step(4);
    rd("R8 falling sets", 12'h048, 32'h2);
    wr(12'h04C, 32'h2);
    pad_in = 32'h4;
    step(4);
    rd("R8 both rise", 12'h048, 32'h4);
    wr(12'h04C, 32'h4);
    pad_in = 32'h0;
    step(4);
    rd("R8 both fall", 12'h048, 32'h4);
    pad_in = 32'h1;
    step(4);
    rd("R7 second pending", 12'h048, 32'h5);
    wr(12'h04C, 32'h1);
    rd("R9 partial ack", 12'h048, 32'h4);
    port("R10 irq held", {31'h0, irq}, 32'h1);
    wr(12'h04C, 32'hFFFF_FFFF);
    rd("R9 ack all", 12'h048, 32'h0);
    pad_in = 32'h5;
    step(2);
    wr(12'h04C, 32'h4);
    rd("R9 edge beats ack", 12'h048, 32'h4);
    wr(12'h040, 32'h0);
    wr(12'h044, 32'h0);
    wr(12'h04C, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    step(4);
    rd("R8 masks off", 12'h048, 32'h0);
    port("R10 irq idle", {31'h0, irq}, 32'h0);
    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule